// File: doc/BRIEF.md
# Heartbeat Activity Watchdog

This block watches a single heartbeat line toggled by processor firmware and asks the reset generator for a reset when that line has stopped changing for a fixed number of clock cycles. The line is brought into the clock domain through a flop synchronizer. Every change of level, rising or falling, restarts the quiet-time count. When the count reaches the limit, the block emits a one-cycle expiry strobe and starts counting again from zero. The nominal limit is 1.6 s, set as a cycle count through a parameter.

The reset generator feeds back a level that is high while system reset is asserted. While that level is high, the count is held at zero. The watchdog cannot be switched off. A line that is tied off or left idle simply expires again every timeout period. A test port exposes the running count, and a flag shows when the count has reached half the limit, so a reduced limit can be used to check the block quickly.

No data streams through this block, so it has no valid/ready interface and no back-pressure rules. All pins are plain control or status levels.

Top module: `hb_watchdog`

## Requirements
- R1: With the synchronized heartbeat level unchanged and no hold, the count advances by one per clock. After TIMEOUT_CYC quiet clocks, counted from zero, `expire_o` is high for one cycle.
- R2: A low-to-high change of the heartbeat clears the count to zero.
- R3: A high-to-low change of the heartbeat clears the count to zero.
- R4: While `sys_rst_act` is high, the count is zero and `expire_o` stays low. Counting resumes from zero on the first clock after it drops.
- R5: `expire_o` lasts exactly one cycle, and the count is zero in that cycle. A line that stays quiet produces a new strobe every TIMEOUT_CYC cycles, with no way to disable it.
- R6: A heartbeat change applied before clock edge k takes effect on the count at edge k+2. The count keeps advancing at edges k and k+1.
- R7: When a heartbeat change reaches the counter on the same edge at which the count would expire, the clear wins and no strobe is issued. A `sys_rst_act` high on that edge also suppresses the strobe.
- R8: `count_o` shows the current quiet-cycle count. `half_o` is high exactly when `count_o` is at least TIMEOUT_CYC/2.
- R9: While `rst_n` is low, `count_o` is zero, `expire_o` is low and `half_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| hb_in | input | 1 | Asynchronous heartbeat line from firmware |
| sys_rst_act | input | 1 | High while system reset is asserted; holds the count at zero |
| expire_o | output | 1 | One-cycle timeout strobe to the reset generator |
| count_o | output | CNT_W = clog2(TIMEOUT_CYC) | Current quiet-cycle count (test) |
| half_o | output | 1 | Count has reached half the limit (test) |

## Verification
Two pairs of functions can land on the same clock edge. The first is a heartbeat clear arriving on the edge where the count would expire. The bench provokes it by toggling the line exactly two edges before the count reaches its terminal value. It passes if no strobe appears and the count reads zero. The second is a system-reset hold raised for one cycle while the count sits at its terminal value, which must likewise give no strobe and a zero count, with a full timeout needed before the next strobe.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
  typedef enum logic [1:0] {
    HB_NONE = 2'b00,
    HB_RISE = 2'b01,
    HB_FALL = 2'b10
  } hb_edge_e;
endpackage

// File: rtl/hbw_sync.sv
module hbw_sync #(
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hb_i,
  output hbw_pkg::hb_edge_e kind_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              level;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= hb_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], hb_i};
      end
    end
  endgenerate

  assign level = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  always_comb begin
    if (level && !prev_q)      kind_o = hbw_pkg::HB_RISE;
    else if (!level && prev_q) kind_o = hbw_pkg::HB_FALL;
    else                       kind_o = hbw_pkg::HB_NONE;
  end
endmodule

// File: rtl/hbw_counter.sv
module hbw_counter #(
  parameter int TIMEOUT_CYC = 400_000_000,
  parameter int CNT_W       = $clog2(TIMEOUT_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             expire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else if (hold_i || clr_i) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q    <= '0;
      expire_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      expire_q <= 1'b0;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = expire_q;

  // R4: hold forces zero and no strobe
  p_hold_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == '0 && !expire_q));

  // R7: a heartbeat clear beats a pending expiry
  p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hold_i) |=> (cnt_q == '0 && !expire_q));

  // R1: quiet cycles advance the count
  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !clr_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1 && !expire_q));

  // R5: strobe coincides with a restarted count
  p_expire_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> (cnt_q == '0));

  // R5: strobe is one cycle wide
  p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |=> !expire_q);
endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog #(
  parameter int TIMEOUT_CYC = 400_000_000,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(TIMEOUT_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hb_in,
  input  logic             sys_rst_act,
  output logic             expire_o,
  output logic [CNT_W-1:0] count_o,
  output logic             half_o
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(TIMEOUT_CYC / 2);

  hbw_pkg::hb_edge_e kind;
  logic              clr;

  hbw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .hb_i   (hb_in),
    .kind_o (kind)
  );

  assign clr = (kind != hbw_pkg::HB_NONE);

  hbw_counter #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (sys_rst_act),
    .clr_i    (clr),
    .cnt_o    (count_o),
    .expire_o (expire_o)
  );

  assign half_o = (count_o >= HALF);
endmodule

// File: tb/tb_hb_watchdog.sv
`timescale 1ns/1ps
module tb_hb_watchdog;
  localparam int T  = 16;
  localparam int CW = $clog2(T);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hb_in = 1'b0;
  logic sys_rst_act = 1'b0;
  logic expire_o;
  logic [CW-1:0] count_o;
  logic half_o;

  int n_chk = 0;
  int n_fail = 0;
  int pulses;

  always #2 clk = ~clk;

  hb_watchdog #(.TIMEOUT_CYC(T), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .hb_in(hb_in), .sys_rst_act(sys_rst_act),
    .expire_o(expire_o), .count_o(count_o), .half_o(half_o)
  );

  // Stimulus table: heartbeat level, hold, cycles, expected strobes, count
  localparam int NV = 8;
  localparam int V_HB  [NV] = '{0, 1, 1, 0, 0, 0, 0, 0};
  localparam int V_SYS [NV] = '{0, 0, 0, 0, 1, 0, 0, 0};
  localparam int V_N   [NV] = '{10, 10, 20, 5, 40, 16, 32, 5};
  localparam int V_PUL [NV] = '{0, 0, 1, 0, 0, 1, 2, 0};
  localparam int V_CNT [NV] = '{10, 7, 11, 2, 0, 0, 0, 5};
  localparam string V_REQ [NV] = '{"R1", "R2", "R5", "R3", "R4", "R5", "R5", "R1"};

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int n);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pulses += int'(expire_o);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "count in reset", int'(count_o), 0);
    chk("R9", "strobe in reset", int'(expire_o), 0);
    chk("R9", "half in reset", int'(half_o), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      hb_in = V_HB[v][0];
      sys_rst_act = V_SYS[v][0];
      run(V_N[v]);
      chk(V_REQ[v], "strobes", pulses, V_PUL[v]);
      chk(V_REQ[v], "count", int'(count_o), V_CNT[v]);
      chk("R8", "half flag", int'(half_o), (V_CNT[v] >= T / 2) ? 1 : 0);
    end

    // R7: edge reaches counter on the terminal-count edge
    run(8);
    chk("R7", "count before toggle", int'(count_o), 13);
    hb_in = 1'b1;
    run(3);
    chk("R7", "strobe on coincident edge", pulses, 0);
    chk("R7", "count after coincident edge", int'(count_o), 0);

    // R7: hold pulse at terminal count
    run(15);
    chk("R8", "count at terminal", int'(count_o), T - 1);
    chk("R8", "half at terminal", int'(half_o), 1);
    sys_rst_act = 1'b1;
    run(1);
    chk("R7", "strobe under hold", pulses, 0);
    chk("R4", "count under hold", int'(count_o), 0);
    sys_rst_act = 1'b0;
    run(15);
    chk("R4", "no early strobe after hold", pulses, 0);
    run(1);
    chk("R1", "strobe after full timeout", pulses, 1);
    chk("R5", "count at strobe", int'(count_o), 0);

    // R6: latency of a change through the synchronizer
    run(5);
    hb_in = 1'b0;
    run(2);
    chk("R6", "count still advancing", int'(count_o), 7);
    run(1);
    chk("R6", "count cleared at third edge", int'(count_o), 0);

    // R9: block reset mid-count
    run(4);
    rst_n = 1'b0;
    run(1);
    chk("R9", "count after reset", int'(count_o), 0);
    chk("R9", "strobe after reset", int'(expire_o), 0);
    rst_n = 1'b1;
    run(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule